// File: doc/BRIEF.md
# Receive Character Queue with Per-Byte Error Tags

This block sits on the receive side of a serial port, directly behind a deserializer that has already assembled each character. Every completed character comes in with three flags: a parity fault, a missing stop bit, and a break. The block stores the character and its flags together in one queue entry. The oldest entry is shown on the receive data output. An 8-bit line status word reports whether data is waiting, whether a character was lost, the flags of the byte currently shown, and whether any stored byte anywhere in the queue carries a flag.

A host reads the status word to learn the state of the receiver. It pulses a read strobe to take the oldest byte, which brings the next byte and that byte's flags to the head. When queueing is disabled, the same logic acts as a single holding register. A continuous break is entered only once in queued mode: the line has to be seen idle again before another break character is accepted.

Top module: `rx_status_fifo`

## Requirements
- R1: After reset, `rx_data` and all eight bits of `line_stat` are 0. Bits 6 and 5 of `line_stat` are always 0.
- R2: `line_stat[0]` is 1 exactly when at least one byte is stored, and 0 when the store is empty.
- R3: In queued mode (`fifo_en`=1) up to 64 bytes are kept in arrival order. `rx_data` shows the oldest byte, or 0 when the store is empty. Each `rx_rd` pulse removes one byte. A pulse while the store is empty has no effect.
- R4: When a character arrives while the store is full and no byte is removed in that cycle, `line_stat[1]` is set and the character is dropped. The stored bytes are unchanged.
- R5: `line_stat[1]` goes to 0 in the cycle after a `stat_rd` pulse, unless a new loss occurs in that same cycle.
- R6: `line_stat[2]` (parity), `line_stat[3]` (stop bit) and `line_stat[4]` (break) are the flags stored with the byte shown on `rx_data`. They are 0 when the store is empty.
- R7: `line_stat[7]` is 1 while any stored byte carries at least one flag. It returns to 0 once the last flagged byte has been removed, even if clean bytes remain.
- R8: In queued mode, after one break character has been accepted, further break characters are discarded until `line_idle` has been seen high. Discarded break characters do not set `line_stat[1]`. In single mode every break character is handled like any other character.
- R9: In single mode (`fifo_en`=0) the store holds one byte. A second character that arrives before the first is read sets `line_stat[1]`, and the first byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = 64-entry queue, 0 = single holding register |
| ch_valid | input | 1 | One-cycle strobe: a character is complete |
| ch_data | input | 8 | Received character |
| ch_perr | input | 1 | Parity fault for this character |
| ch_ferr | input | 1 | Missing stop bit for this character |
| ch_brk | input | 1 | This character is a break |
| line_idle | input | 1 | Receive line seen high; re-arms break capture |
| rx_rd | input | 1 | Host takes the head byte |
| stat_rd | input | 1 | Host reads the status word |
| rx_data | output | 8 | Head byte, or 0 when empty |
| line_stat | output | 8 | {any-flag, 0, 0, break, stop-bit, parity, lost, ready} |

## Verification
The queue is filled to its full depth with a counting pattern and then drained. This shows both ordering and the exact full boundary, where a 65th byte must raise the loss flag and must not appear in the data that is read back. A run of bytes that each carry a different single flag, read out one at a time, shows that the per-byte status follows the head rather than the stream. A flagged byte followed by a clean one separates the queue-wide flag from the head flags. Repeated break characters, sent with and without an idle pulse between them and in both modes, separate the one-shot break capture from ordinary loading.

// File: rtl/rx_status_fifo.sv
module rx_status_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          ch_valid,
  input  logic [DW-1:0] ch_data,
  input  logic          ch_perr,
  input  logic          ch_ferr,
  input  logic          ch_brk,
  input  logic          line_idle,
  input  logic          rx_rd,
  input  logic          stat_rd,
  output logic [DW-1:0] rx_data,
  output logic [7:0]    line_stat
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DW + 3;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt, err_cnt;
  logic          ovr, brk_armed;

  wire [CW-1:0] cap       = fifo_en ? CW'(DEPTH) : CW'(1);
  wire          empty     = (cnt == '0);
  wire          full      = (cnt >= cap);
  wire          pop       = rx_rd && !empty;
  wire          brk_drop  = fifo_en && ch_brk && !brk_armed;
  wire          arrive    = ch_valid && !brk_drop;
  wire          push      = arrive && (!full || pop);
  wire          ovr_set   = arrive && !push;
  wire          tag_in    = ch_perr | ch_ferr | ch_brk;
  wire [EW-1:0] head      = mem[rd_ptr];
  wire          tag_out   = |head[EW-1:DW];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= {ch_brk, ch_ferr, ch_perr, ch_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      err_cnt   <= '0;
      ovr       <= 1'b0;
      brk_armed <= 1'b1;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      cnt     <= cnt + CW'(push) - CW'(pop);
      err_cnt <= err_cnt + CW'(push && tag_in) - CW'(pop && tag_out);
      if (ovr_set)      ovr <= 1'b1;
      else if (stat_rd) ovr <= 1'b0;
      if (fifo_en && ch_valid && ch_brk) brk_armed <= 1'b0;
      else if (line_idle)                brk_armed <= 1'b1;
    end
  end

  assign rx_data   = empty ? '0 : head[DW-1:0];
  assign line_stat = {err_cnt != '0, 2'b00,
                      empty ? 3'b000 : head[EW-1:DW], ovr, !empty};

  p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  p_drop_on_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_valid && !brk_drop && full && !rx_rd) |=> (cnt == $past(cnt)) && line_stat[1]);

  p_ovr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ovr_set) |=> !line_stat[1]);

  p_errcnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= cnt);

  p_last_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !ch_valid && cnt == CW'(1)) |=> !line_stat[0]);

  p_brk_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_valid && brk_drop && !rx_rd) |=> (cnt == $past(cnt)) && ($past(ovr) || !ovr));
endmodule

// File: tb/test_rx_status_fifo.sv
module test_rx_status_fifo;
  logic clk = 0, rst_n = 0;
  logic fifo_en = 1, ch_valid = 0, ch_perr = 0, ch_ferr = 0, ch_brk = 0;
  logic line_idle = 0, rx_rd = 0, stat_rd = 0;
  logic [7:0] ch_data = 0, rx_data, line_stat;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_status_fifo i_rx_status_fifo (
    .clk, .rst_n, .fifo_en, .ch_valid, .ch_data, .ch_perr, .ch_ferr, .ch_brk,
    .line_idle, .rx_rd, .stat_rd, .rx_data, .line_stat);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic p, input logic f, input logic b);
    @(negedge clk);
    ch_valid = 1; ch_data = d; ch_perr = p; ch_ferr = f; ch_brk = b;
    @(negedge clk);
    ch_valid = 0; ch_perr = 0; ch_ferr = 0; ch_brk = 0;
  endtask

  task automatic take();
    @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;
  endtask

  task automatic read_stat();
    @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0;
  endtask

  task automatic idle_pulse();
    @(negedge clk); line_idle = 1; @(negedge clk); line_idle = 0;
  endtask

  task automatic t_reset();
    check(line_stat == 8'h00, "R1 status", line_stat, 0);
    check(rx_data == 8'h00, "R1 data", rx_data, 0);
  endtask

  task automatic t_fill_drain();
    bit ord_ok = 1;
    fifo_en = 1;
    for (int i = 0; i < 64; i++) put(8'(i * 3 + 1), 0, 0, 0);
    check(line_stat == 8'h01, "R2 ready when full", line_stat, 8'h01);
    put(8'hEE, 0, 0, 0);
    check(line_stat[1] == 1, "R4 loss flag", line_stat[1], 1);
    check(rx_data == 8'h01, "R4 head kept", rx_data, 8'h01);
    read_stat();
    check(line_stat[1] == 0, "R5 loss cleared", line_stat[1], 0);
    for (int i = 0; i < 64; i++) begin
      if (rx_data != 8'(i * 3 + 1)) begin
        ord_ok = 0;
        check(0, "R3 order", rx_data, i * 3 + 1);
      end
      take();
    end
    check(ord_ok, "R3 all 64 in order", ord_ok, 1);
    check(line_stat[0] == 0, "R2 empty after drain", line_stat, 0);
    take();
    check(line_stat == 8'h00 && rx_data == 8'h00, "R3 read on empty ignored", line_stat, 0);
  endtask

  task automatic t_tags();
    idle_pulse();
    put(8'h11, 0, 0, 0);
    put(8'h22, 1, 0, 0);
    put(8'h33, 0, 1, 0);
    put(8'h00, 0, 0, 1);
    check(line_stat == 8'h81, "R6 clean head, R7 set", line_stat, 8'h81);
    take();
    check(line_stat == 8'h85 && rx_data == 8'h22, "R6 parity head", line_stat, 8'h85);
    take();
    check(line_stat == 8'h89 && rx_data == 8'h33, "R6 stop-bit head", line_stat, 8'h89);
    take();
    check(line_stat == 8'h91, "R6 break head", line_stat, 8'h91);
    take();
    check(line_stat == 8'h00, "R7 cleared when empty", line_stat, 0);
  endtask

  task automatic t_errflag();
    put(8'h44, 1, 1, 0);
    put(8'h55, 0, 0, 0);
    check(line_stat == 8'h8D, "R7 flagged head", line_stat, 8'h8D);
    take();
    check(line_stat == 8'h01 && rx_data == 8'h55, "R7 clear with clean bytes left", line_stat, 8'h01);
    take();
  endtask

  task automatic t_break();
    idle_pulse();
    put(8'h00, 0, 1, 1);
    put(8'h00, 0, 1, 1);
    put(8'h00, 0, 1, 1);
    check(line_stat == 8'h99, "R8 first break loaded", line_stat, 8'h99);
    take();
    check(line_stat == 8'h00, "R8 repeats dropped, no loss", line_stat, 0);
    idle_pulse();
    put(8'h00, 0, 1, 1);
    check(line_stat[4] == 1 && line_stat[0] == 1, "R8 re-armed after idle", line_stat, 8'h99);
    take();
  endtask

  task automatic t_single();
    fifo_en = 0;
    put(8'h5A, 0, 0, 0);
    put(8'hA5, 0, 0, 0);
    check(line_stat == 8'h03, "R9 loss in single mode", line_stat, 8'h03);
    check(rx_data == 8'h5A, "R9 first byte kept", rx_data, 8'h5A);
    take();
    check(line_stat == 8'h02, "R9 empty after read", line_stat, 8'h02);
    read_stat();
    put(8'h00, 0, 0, 1);
    take();
    put(8'h00, 0, 0, 1);
    check(line_stat == 8'h91, "R8 single mode loads every break", line_stat, 8'h91);
    take();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill_drain();
    t_tags();
    t_errflag();
    t_break();
    t_single();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule